// File: doc/BRIEF.md
# Fixed-Slot Raster and Service Timing Generator

This block splits the machine clock into fixed 43-cycle slots. It then groups those slots into a ladder of coarser periods. Five slots make a scan line and four lines make a service block. One hundred and sixty blocks make a frame of 640 lines. At the nominal 8.25 MHz machine clock these periods come to about 192 kHz for slots, 38.4 kHz for lines, 9.6 kHz for blocks and 60 Hz for frames. The raster timing and the low-rate serial and audio pacing therefore all come from one counter chain.

The first slot of every line is the sync slot, and an active-low horizontal sync pulse is driven at its start. In the first line of each block, the slot after the sync slot is kept for block bookkeeping. The other fifteen slots of a block are flagged as free for general code. A one-cycle block strobe paces the per-block services. An active-low vertical sync covers a fixed run of whole lines near the end of the frame. The current slot, line and block indices are presented with the cycle count inside the slot. Every output is a register, and all of them describe the same cycle.

Top module: `slot_timing_gen`

## Requirements
- R1: While `rst` is high, the outputs show the final cycle of a frame: `slot_cyc`=42, `slot_idx`=4, `line_idx`=3, `blk_idx`=159, `hsync_n`=1, `blk_stb`=0, `book_slot`=0, `free_slot`=1, `vsync_n`=1. The first cycle after release is cycle 0 of slot 0, line 0, block 0.
- R2: `slot_cyc` counts 0..42 once per clock and wraps. `slot_idx` counts 0..4 and advances only when `slot_cyc` wraps.
- R3: `line_idx` counts 0..3 and advances when `slot_idx` wraps. `blk_idx` counts 0..159, advances when `line_idx` wraps, and returns to 0 after 159.
- R4: `hsync_n` is low for exactly cycles 0..5 of slot 0 of every line and high in all other cycles, giving 640 pulses per frame.
- R5: `blk_stb` is high for a single cycle, cycle 0 of slot 0 of line 0 of every block, giving 160 per frame.
- R6: `book_slot` is high for all 43 cycles of slot 1 of line 0 in each block and low elsewhere.
- R7: `free_slot` is high exactly when the slot is neither slot 0 nor the bookkeeping slot. This makes 15 of the 20 slots of each block free.
- R8: `vsync_n` is low during whole frame lines 630 and 631, where frame line = `blk_idx`*4 + `line_idx`, and high on all other lines.
- R9: Asserting `rst` in the middle of a frame returns the outputs to the R1 view on the next edge. After release the sequence restarts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blk_stb | output | 1 | One-cycle strobe at each block start |
| book_slot | output | 1 | Block bookkeeping slot in progress |
| free_slot | output | 1 | Slot available to general code |
| slot_cyc | output | 6 | Cycle inside the current slot |
| slot_idx | output | 3 | Slot inside the current line |
| line_idx | output | 2 | Line inside the current block |
| blk_idx | output | 8 | Block inside the current frame |

## Verification
The flags are decoded from the counters' next values and loaded on the same edge as the counters. Every output therefore describes one position, and no output lags another. The first rising edge after `rst` falls presents position 0, and each later edge advances the position by one. The bench counts rising edges from release, samples every output on the following falling edge, and compares it with the position it derives from that count. The mid-frame reset check is taken one edge after `rst` rises, and again one edge after it falls.

// File: rtl/slot_timing_pkg.sv
package slot_timing_pkg;

  // Per-cycle flags decoded from a timing position
  typedef struct packed {
    logic hsync_n;
    logic vsync_n;
    logic blk_stb;
    logic book;
    logic free;
  } slot_flags_t;

endpackage

// File: rtl/slot_timing_stage.sv
// One wrapping digit of the timing chain. Reset parks it at its last value
// so that the first edge after release lands on zero.
module slot_timing_stage #(
  parameter int MOD = 43,
  localparam int W = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nx
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_comb begin
    if (!step)
      cnt_nx = cnt;
    else if (cnt == LAST)
      cnt_nx = '0;
    else
      cnt_nx = cnt + W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= LAST;
    else
      cnt <= cnt_nx;
  end

endmodule

// File: rtl/slot_timing_decode.sv
// Pure decode of one timing position into its output flags.
module slot_timing_decode
  import slot_timing_pkg::*;
#(
  parameter int SLOT_CYC  = 43,
  parameter int SLOTS     = 5,
  parameter int LINES     = 4,
  parameter int BLOCKS    = 160,
  parameter int HS_CYC    = 6,
  parameter int BOOK_SLOT = 1,
  parameter int VS_FIRST  = 630,
  parameter int VS_LINES  = 2,
  localparam int CW = $clog2(SLOT_CYC),
  localparam int SW = $clog2(SLOTS),
  localparam int LW = $clog2(LINES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic [CW-1:0] cyc,
  input  logic [SW-1:0] slot,
  input  logic [LW-1:0] line,
  input  logic [BW-1:0] blk,
  output slot_flags_t   flags
);

  int   frame_line;
  logic in_sync_slot;
  logic in_book_slot;

  always_comb begin
    frame_line   = int'(blk) * LINES + int'(line);
    in_sync_slot = (slot == '0);
    in_book_slot = (line == '0) && (int'(slot) == BOOK_SLOT);

    flags.hsync_n = !(in_sync_slot && (int'(cyc) < HS_CYC));
    flags.blk_stb = in_sync_slot && (line == '0) && (cyc == '0);
    flags.book    = in_book_slot;
    flags.free    = !in_sync_slot && !in_book_slot;
    flags.vsync_n = !((frame_line >= VS_FIRST) &&
                      (frame_line < VS_FIRST + VS_LINES));
  end

endmodule

// File: rtl/slot_timing_gen.sv
// Slot / line / block / frame timing chain with registered outputs.
module slot_timing_gen
  import slot_timing_pkg::*;
#(
  parameter int SLOT_CYC  = 43,
  parameter int SLOTS     = 5,
  parameter int LINES     = 4,
  parameter int BLOCKS    = 160,
  parameter int HS_CYC    = 6,
  parameter int BOOK_SLOT = 1,
  parameter int VS_FIRST  = 630,
  parameter int VS_LINES  = 2,
  localparam int CW = $clog2(SLOT_CYC),
  localparam int SW = $clog2(SLOTS),
  localparam int LW = $clog2(LINES),
  localparam int BW = $clog2(BLOCKS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blk_stb,
  output logic          book_slot,
  output logic          free_slot,
  output logic [CW-1:0] slot_cyc,
  output logic [SW-1:0] slot_idx,
  output logic [LW-1:0] line_idx,
  output logic [BW-1:0] blk_idx
);

  localparam logic [CW-1:0] CYC_LAST  = CW'(SLOT_CYC - 1);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);
  localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);
  localparam logic [BW-1:0] BLK_LAST  = BW'(BLOCKS - 1);

  logic [CW-1:0] cyc_nx;
  logic [SW-1:0] slot_nx;
  logic [LW-1:0] line_nx;
  logic [BW-1:0] blk_nx;

  logic cyc_end, slot_step, line_step, blk_step;

  // Carry chain between the digits
  assign cyc_end   = (slot_cyc == CYC_LAST);
  assign slot_step = cyc_end;
  assign line_step = slot_step && (slot_idx == SLOT_LAST);
  assign blk_step  = line_step && (line_idx == LINE_LAST);

  slot_timing_stage #(.MOD(SLOT_CYC)) u_cyc (
    .clk(clk), .rst(rst), .step(1'b1), .cnt(slot_cyc), .cnt_nx(cyc_nx));
  slot_timing_stage #(.MOD(SLOTS)) u_slot (
    .clk(clk), .rst(rst), .step(slot_step), .cnt(slot_idx), .cnt_nx(slot_nx));
  slot_timing_stage #(.MOD(LINES)) u_line (
    .clk(clk), .rst(rst), .step(line_step), .cnt(line_idx), .cnt_nx(line_nx));
  slot_timing_stage #(.MOD(BLOCKS)) u_blk (
    .clk(clk), .rst(rst), .step(blk_step), .cnt(blk_idx), .cnt_nx(blk_nx));

  slot_flags_t nx_flags;
  slot_flags_t park_flags;

  // Flags of the position the counters are about to enter
  slot_timing_decode #(
    .SLOT_CYC(SLOT_CYC), .SLOTS(SLOTS), .LINES(LINES), .BLOCKS(BLOCKS),
    .HS_CYC(HS_CYC), .BOOK_SLOT(BOOK_SLOT),
    .VS_FIRST(VS_FIRST), .VS_LINES(VS_LINES)
  ) u_dec_next (
    .cyc(cyc_nx), .slot(slot_nx), .line(line_nx), .blk(blk_nx),
    .flags(nx_flags));

  // Flags of the parked (last) position held during reset
  slot_timing_decode #(
    .SLOT_CYC(SLOT_CYC), .SLOTS(SLOTS), .LINES(LINES), .BLOCKS(BLOCKS),
    .HS_CYC(HS_CYC), .BOOK_SLOT(BOOK_SLOT),
    .VS_FIRST(VS_FIRST), .VS_LINES(VS_LINES)
  ) u_dec_park (
    .cyc(CYC_LAST), .slot(SLOT_LAST), .line(LINE_LAST), .blk(BLK_LAST),
    .flags(park_flags));

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_n   <= park_flags.hsync_n;
      vsync_n   <= park_flags.vsync_n;
      blk_stb   <= park_flags.blk_stb;
      book_slot <= park_flags.book;
      free_slot <= park_flags.free;
    end else begin
      hsync_n   <= nx_flags.hsync_n;
      vsync_n   <= nx_flags.vsync_n;
      blk_stb   <= nx_flags.blk_stb;
      book_slot <= nx_flags.book;
      free_slot <= nx_flags.free;
    end
  end

endmodule

// File: rtl/slot_timing_chk.sv
module slot_timing_chk #(
  parameter int SLOT_CYC  = 43,
  parameter int SLOTS     = 5,
  parameter int LINES     = 4,
  parameter int BLOCKS    = 160,
  parameter int HS_CYC    = 6,
  parameter int BOOK_SLOT = 1,
  localparam int CW = $clog2(SLOT_CYC),
  localparam int SW = $clog2(SLOTS),
  localparam int LW = $clog2(LINES),
  localparam int BW = $clog2(BLOCKS)
) (
  input logic          clk,
  input logic          rst,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          blk_stb,
  input logic          book_slot,
  input logic          free_slot,
  input logic [CW-1:0] slot_cyc,
  input logic [SW-1:0] slot_idx,
  input logic [LW-1:0] line_idx,
  input logic [BW-1:0] blk_idx
);

  p_slot_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (slot_cyc != '0) |-> $stable(slot_idx));

  p_blk_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    ((int'($past(blk_idx)) == BLOCKS - 1) && !$stable(blk_idx)) |->
    (blk_idx == '0));

  p_hsync_place_r4: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> ((slot_idx == '0) && (int'(slot_cyc) < HS_CYC)));

  p_stb_place_r5: assert property (@(posedge clk) disable iff (rst)
    blk_stb |-> ((slot_idx == '0) && (line_idx == '0) && (slot_cyc == '0)));

  p_stb_single_r5: assert property (@(posedge clk) disable iff (rst)
    blk_stb |=> !blk_stb);

  p_book_place_r6: assert property (@(posedge clk) disable iff (rst)
    book_slot |-> ((line_idx == '0) && (int'(slot_idx) == BOOK_SLOT)));

  p_flag_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({free_slot, book_slot, !hsync_n}));

  p_vsync_edge_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(vsync_n) || $rose(vsync_n)) |->
    ((slot_idx == '0) && (slot_cyc == '0)));

endmodule

bind slot_timing_gen slot_timing_chk #(
  .SLOT_CYC(SLOT_CYC), .SLOTS(SLOTS), .LINES(LINES), .BLOCKS(BLOCKS),
  .HS_CYC(HS_CYC), .BOOK_SLOT(BOOK_SLOT)
) u_chk (
  .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .blk_stb(blk_stb), .book_slot(book_slot), .free_slot(free_slot),
  .slot_cyc(slot_cyc), .slot_idx(slot_idx), .line_idx(line_idx),
  .blk_idx(blk_idx));

// File: tb/slot_timing_gen_bench.sv
module slot_timing_gen_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       hsync_n, vsync_n, blk_stb, book_slot, free_slot;
  logic [5:0] slot_cyc;
  logic [2:0] slot_idx;
  logic [1:0] line_idx;
  logic [7:0] blk_idx;

  slot_timing_gen u_slot_timing_gen (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blk_stb(blk_stb), .book_slot(book_slot), .free_slot(free_slot),
    .slot_cyc(slot_cyc), .slot_idx(slot_idx), .line_idx(line_idx),
    .blk_idx(blk_idx));

  localparam int FRAME = 137600;

  int checks = 0;
  int bad    = 0;
  int pos    = -1;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    pos++;
    @(negedge clk);
  endtask

  // position, slot, line, block, hsync_n, stb, book, free, vsync_n
  typedef struct packed {
    int p; int s; int l; int b;
    logic hs; logic stb; logic bk; logic fr; logic vs;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t TBL [NV] = '{
    '{0,      0, 0, 0,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{5,      0, 0, 0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{6,      0, 0, 0,   1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{43,     1, 0, 0,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{85,     1, 0, 0,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{86,     2, 0, 0,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{215,    0, 1, 0,   1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{258,    1, 1, 0,   1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{860,    0, 0, 1,   1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{903,    1, 0, 1,   1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{135449, 4, 1, 157, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{135450, 0, 2, 157, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{135879, 4, 3, 157, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{135880, 0, 0, 158, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{137599, 4, 3, 159, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1}
  };

  task automatic check_parked(input string tag);
    chk({tag, " cyc"},  int'(slot_cyc), 42);
    chk({tag, " slot"}, int'(slot_idx), 4);
    chk({tag, " line"}, int'(line_idx), 3);
    chk({tag, " blk"},  int'(blk_idx), 159);
    chk({tag, " hs"},   int'(hsync_n), 1);
    chk({tag, " stb"},  int'(blk_stb), 0);
    chk({tag, " book"}, int'(book_slot), 0);
    chk({tag, " free"}, int'(free_slot), 1);
    chk({tag, " vs"},   int'(vsync_n), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int mm_idx = 0, mm_hs = 0, mm_stb = 0, mm_bk = 0, mm_fr = 0, mm_vs = 0;
    int n_hfall = 0, n_stb = 0, n_bk = 0, n_fr = 0, n_vs = 0;
    int prev_hs = 1;
    int ti = 0;

    repeat (4) @(posedge clk);
    @(negedge clk);
    check_parked("R1 reset view");
    rst = 1'b0;
    pos = -1;

    for (int k = 0; k <= FRAME; k++) begin
      int mc, ms, ml, mb, fl;
      int e_hs, e_stb, e_bk, e_fr, e_vs;
      step();
      mc = pos % 43;
      ms = (pos / 43) % 5;
      ml = (pos / 215) % 4;
      mb = (pos / 860) % 160;
      fl = mb * 4 + ml;
      e_hs  = (ms == 0 && mc < 6) ? 0 : 1;
      e_stb = (ms == 0 && ml == 0 && mc == 0) ? 1 : 0;
      e_bk  = (ml == 0 && ms == 1) ? 1 : 0;
      e_fr  = (ms != 0 && e_bk == 0) ? 1 : 0;
      e_vs  = (fl >= 630 && fl < 632) ? 0 : 1;

      if (int'(slot_cyc) != mc || int'(slot_idx) != ms ||
          int'(line_idx) != ml || int'(blk_idx) != mb) mm_idx++;
      if (int'(hsync_n)   != e_hs)  mm_hs++;
      if (int'(blk_stb)   != e_stb) mm_stb++;
      if (int'(book_slot) != e_bk)  mm_bk++;
      if (int'(free_slot) != e_fr)  mm_fr++;
      if (int'(vsync_n)   != e_vs)  mm_vs++;

      if (pos < FRAME) begin
        if (prev_hs == 1 && hsync_n == 1'b0) n_hfall++;
        if (blk_stb)   n_stb++;
        if (book_slot) n_bk++;
        if (free_slot) n_fr++;
        if (!vsync_n)  n_vs++;
      end
      prev_hs = int'(hsync_n);

      if (ti < NV && TBL[ti].p == pos) begin
        chk($sformatf("R2 slot @%0d", pos), int'(slot_idx), TBL[ti].s);
        chk($sformatf("R3 line @%0d", pos), int'(line_idx), TBL[ti].l);
        chk($sformatf("R3 blk @%0d", pos),  int'(blk_idx),  TBL[ti].b);
        chk($sformatf("R4 hsync @%0d", pos), int'(hsync_n), int'(TBL[ti].hs));
        chk($sformatf("R5 stb @%0d", pos),  int'(blk_stb),  int'(TBL[ti].stb));
        chk($sformatf("R6 book @%0d", pos), int'(book_slot), int'(TBL[ti].bk));
        chk($sformatf("R7 free @%0d", pos), int'(free_slot), int'(TBL[ti].fr));
        chk($sformatf("R8 vsync @%0d", pos), int'(vsync_n), int'(TBL[ti].vs));
        ti++;
      end
    end

    // Frame wrap back to the first position (R3, R5)
    chk("R3 wrap blk", int'(blk_idx), 0);
    chk("R5 wrap stb", int'(blk_stb), 1);

    chk("R2 R3 index mismatches", mm_idx, 0);
    chk("R4 hsync mismatches", mm_hs, 0);
    chk("R5 strobe mismatches", mm_stb, 0);
    chk("R6 book mismatches", mm_bk, 0);
    chk("R7 free mismatches", mm_fr, 0);
    chk("R8 vsync mismatches", mm_vs, 0);
    chk("R4 hsync pulses per frame", n_hfall, 640);
    chk("R5 strobes per frame", n_stb, 160);
    chk("R6 book cycles per frame", n_bk, 160 * 43);
    chk("R7 free cycles per frame", n_fr, 103200);
    chk("R8 vsync cycles per frame", n_vs, 430);
    chk("R1 table entries seen", ti, NV);

    // Mid-frame reset (R9)
    repeat (1000) step();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_parked("R9 mid reset");
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    pos = -1;
    step();
    chk("R9 restart cyc",  int'(slot_cyc), 0);
    chk("R9 restart slot", int'(slot_idx), 0);
    chk("R9 restart blk",  int'(blk_idx), 0);
    chk("R9 restart hs",   int'(hsync_n), 0);
    chk("R9 restart stb",  int'(blk_stb), 1);
    repeat (43) step();
    chk("R9 book after restart", int'(book_slot), 1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule